// File: doc/BRIEF.md
# Grouped-Interrupt General-Purpose Pin Port

This block is a general-purpose pin port with a parameterised pin count (32 by default). Each pin can be driven as an output or sampled as an input. A direction register selects the mode of each pin. A polarity register can invert each input before use. A value register holds the level of every pin, and it has separate set and clear write addresses for output bits.

Input pins pass through a two-flop synchroniser. The value register then follows each input, and a rising effective level latches a bit in a cause register. The pins are split into groups of eight. Each group drives one registered request line to an upstream interrupt controller. A request is raised when a pin with its mask bit set rises.

How a request is released depends on a single mode bit:
- In edge mode, the request is released when software rewrites the cause register.
- In level mode, the request is released when every pin of the group has gone low.

The register port is a single-cycle word-addressed bus. Writes take effect at the clock edge where `bus_sel` and `bus_we` are both high. Reads are combinational while `bus_sel` is high. Word addresses:

| Address | Register |
|---|---|
| 0 | direction (1 = output) |
| 1 | polarity (1 = invert) |
| 2 | value |
| 3 | value-set |
| 4 | value-clear |
| 5 | cause |
| 6 | mask |
| 7 | mask |
| 8 | control |

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction, polarity, value, cause and mask registers read 0, `pin_oe` and `grp_irq` are 0, and the control register (address 8) reads 0x11ff0000.
- R2: A write to the value register (address 2) changes only the bits whose direction bit is 1. `pin_out` follows the value register and `pin_oe` follows the direction register.
- R3: A write to the set address (3) ORs in (data AND direction). A write to the clear address (4) clears (data AND direction). Both addresses read as 0.
- R4: An input pin whose polarity bit is 1 is inverted before it updates the value and cause registers.
- R5: When an input pin's effective level goes from 0 to 1, its value bit and its cause bit are set. If its mask bit is set, request line `grp_irq[pin/8]` is asserted.
- R6: A rising input whose mask bit is 0 sets its cause bit but raises no request.
- R7: A falling input clears its value bit. In level mode, the group's request drops only once all eight value bits of that group are 0.
- R8: In edge mode, falling inputs leave requests set. A write to the cause register (address 5) drops the request of every group whose cause bits changed and are now all 0; other groups keep their request.
- R9: In level mode, a cause-register write only stores the data and leaves every request unchanged.
- R10: Control bit 10 selects the mode (1 = level, 0 = edge). The control register reads 0x11ff0000 OR (mode bit << 10).
- R11: Addresses 6 and 7 both write and read the same mask register.
- R12: A change on an input pin reaches the value register and the request lines at the third rising clock edge after it is applied, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (0 when not selected) |
| pin_in | input | PIN_W | Asynchronous pin levels |
| pin_out | output | PIN_W | Output levels (value register) |
| pin_oe | output | PIN_W | Output enables (direction register) |
| grp_irq | output | PIN_W/8 | One request per group of eight pins |

## Verification
The bench builds the port with its default parameters: 32 pins, groups of 8, and therefore four request lines. With four groups, one test can raise requests in two different groups. It can then clear them one at a time with cause writes, which shows that the edge-mode release acts per group. Groups of eight also let a level-mode test drop one pin of a group while another pin of the same group stays high, so the bench can confirm that the request holds until the whole group is low. The bench measures synchroniser latency by sampling at the second and third edges after a pin change.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int BUS_W    = 32;
  localparam int ADDR_W   = 4;
  localparam int MODE_BIT = 10;
  localparam logic [BUS_W-1:0] CTRL_FIXED = 32'h11ff_0000;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR    = 4'd0,
    REG_POL    = 4'd1,
    REG_VAL    = 4'd2,
    REG_VSET   = 4'd3,
    REG_VCLR   = 4'd4,
    REG_CAUSE  = 4'd5,
    REG_MASK_A = 4'd6,
    REG_MASK_B = 4'd7,
    REG_CTRL   = 4'd8
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int PIN_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [PIN_W-1:0]  pin_sync,
  output logic [PIN_W-1:0]  dir_o,
  output logic [PIN_W-1:0]  val_o,
  output logic [PIN_W-1:0]  val_nxt_o,
  output logic [PIN_W-1:0]  mask_o,
  output logic [PIN_W-1:0]  cause_o,
  output logic [PIN_W-1:0]  cause_new_o,
  output logic              cause_wr_o,
  output logic              level_mode_o,
  output logic [PIN_W-1:0]  rise_o,
  output logic [PIN_W-1:0]  fall_o
);
  logic [PIN_W-1:0] dir_q, pol_q, val_q, cause_q, mask_q;
  logic [PIN_W-1:0] dir_nxt, pol_nxt, val_nxt, cause_nxt, mask_nxt;
  logic             mode_q, mode_nxt;
  logic             wr;
  logic [PIN_W-1:0] wdat, eff, inp, rise, fall, sw_val;

  assign wr   = bus_sel & bus_we;
  assign wdat = bus_wdata[PIN_W-1:0];

  // input sampling and software value update
  always_comb begin
    eff  = pin_sync ^ pol_q;
    inp  = ~dir_q;
    rise = inp & eff & ~val_q;
    fall = inp & ~eff & val_q;

    sw_val = val_q;
    if (wr) begin
      case (bus_addr)
        REG_VAL:  sw_val = (val_q & ~dir_q) | (wdat & dir_q);
        REG_VSET: sw_val = val_q | (wdat & dir_q);
        REG_VCLR: sw_val = val_q & ~(wdat & dir_q);
        default:  sw_val = val_q;
      endcase
    end
    val_nxt = (sw_val & dir_q) | (eff & inp);
  end

  // configuration next state
  always_comb begin
    dir_nxt   = dir_q;
    pol_nxt   = pol_q;
    mask_nxt  = mask_q;
    mode_nxt  = mode_q;
    cause_nxt = cause_q;
    if (wr) begin
      case (bus_addr)
        REG_DIR:    dir_nxt   = wdat;
        REG_POL:    pol_nxt   = wdat;
        REG_MASK_A: mask_nxt  = wdat;
        REG_MASK_B: mask_nxt  = wdat;
        REG_CTRL:   mode_nxt  = bus_wdata[MODE_BIT];
        REG_CAUSE:  cause_nxt = wdat;
        default:    ;
      endcase
    end
    cause_nxt = cause_nxt | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      pol_q   <= '0;
      val_q   <= '0;
      cause_q <= '0;
      mask_q  <= '0;
      mode_q  <= 1'b0;
    end else begin
      dir_q   <= dir_nxt;
      pol_q   <= pol_nxt;
      val_q   <= val_nxt;
      cause_q <= cause_nxt;
      mask_q  <= mask_nxt;
      mode_q  <= mode_nxt;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        REG_DIR:    bus_rdata = BUS_W'(dir_q);
        REG_POL:    bus_rdata = BUS_W'(pol_q);
        REG_VAL:    bus_rdata = BUS_W'(val_q);
        REG_CAUSE:  bus_rdata = BUS_W'(cause_q);
        REG_MASK_A: bus_rdata = BUS_W'(mask_q);
        REG_MASK_B: bus_rdata = BUS_W'(mask_q);
        REG_CTRL:   bus_rdata = CTRL_FIXED | (BUS_W'(mode_q) << MODE_BIT);
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign dir_o        = dir_q;
  assign val_o        = val_q;
  assign val_nxt_o    = val_nxt;
  assign mask_o       = mask_q;
  assign cause_o      = cause_q;
  assign cause_new_o  = wdat;
  assign cause_wr_o   = wr && (bus_addr == REG_CAUSE);
  assign level_mode_o = mode_q;
  assign rise_o       = rise;
  assign fall_o       = fall;

  // R2
  val_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == REG_VAL) |=>
      ((val_q & $past(dir_q)) == ($past(wdat) & $past(dir_q))));

  // R3
  val_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == REG_VSET) |=>
      ((val_q & $past(dir_q) & $past(wdat)) == ($past(dir_q) & $past(wdat))));

  // R11
  mask_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (bus_addr == REG_MASK_A || bus_addr == REG_MASK_B)) |=>
      (mask_q == $past(wdat)));
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] rise,
  input  logic [GW-1:0] fall,
  input  logic [GW-1:0] mask,
  input  logic [GW-1:0] val_nxt,
  input  logic [GW-1:0] cause_old,
  input  logic [GW-1:0] cause_new,
  input  logic          cause_wr,
  input  logic          level_mode,
  output logic          req
);
  logic req_q, req_nxt;
  logic set_req, clr_edge, clr_level;

  always_comb begin
    set_req   = |(rise & mask);
    clr_edge  = !level_mode && cause_wr &&
                (cause_old != cause_new) && (cause_new == '0);
    clr_level = level_mode && (|fall) && (val_nxt == '0);
    if (set_req)                req_nxt = 1'b1;
    else if (clr_edge || clr_level) req_nxt = 1'b0;
    else                        req_nxt = req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_nxt;
  end

  assign req = req_q;

  // R5
  req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> req_q);

  // R8
  edge_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && cause_wr && (cause_old != cause_new) &&
     (cause_new == '0) && !(|(rise & mask))) |=> !req_q);

  // R9
  level_cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && cause_wr && !(|fall) && !(|(rise & mask))) |=>
      (req_q == $past(req_q)));

  // R7
  level_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && (|fall) && (val_nxt == '0) && !(|(rise & mask))) |=> !req_q);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int PIN_W   = 32,
  parameter int GROUP_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [BUS_W-1:0]         bus_wdata,
  output logic [BUS_W-1:0]         bus_rdata,
  input  logic [PIN_W-1:0]         pin_in,
  output logic [PIN_W-1:0]         pin_out,
  output logic [PIN_W-1:0]         pin_oe,
  output logic [PIN_W/GROUP_W-1:0] grp_irq
);
  localparam int NGROUP = PIN_W / GROUP_W;

  logic [PIN_W-1:0] pin_sync, dir, val, val_nxt, mask, cause, cause_new, rise, fall;
  logic             cause_wr, level_mode;

  gpio_sync #(.W(PIN_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  gpio_regs #(.PIN_W(PIN_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_sync(pin_sync),
    .dir_o(dir), .val_o(val), .val_nxt_o(val_nxt), .mask_o(mask),
    .cause_o(cause), .cause_new_o(cause_new), .cause_wr_o(cause_wr),
    .level_mode_o(level_mode), .rise_o(rise), .fall_o(fall)
  );

  for (genvar g = 0; g < NGROUP; g++) begin : g_grp
    gpio_irq_group #(.GW(GROUP_W)) u_grp (
      .clk(clk), .rst_n(rst_n),
      .rise     (rise     [g*GROUP_W +: GROUP_W]),
      .fall     (fall     [g*GROUP_W +: GROUP_W]),
      .mask     (mask     [g*GROUP_W +: GROUP_W]),
      .val_nxt  (val_nxt  [g*GROUP_W +: GROUP_W]),
      .cause_old(cause    [g*GROUP_W +: GROUP_W]),
      .cause_new(cause_new[g*GROUP_W +: GROUP_W]),
      .cause_wr(cause_wr), .level_mode(level_mode),
      .req(grp_irq[g])
    );
  end

  assign pin_out = val;
  assign pin_oe  = dir;
endmodule

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] pin_in, pin_out, pin_oe;
  logic [3:0]  grp_irq;
  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  gpio_port u_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .grp_irq(grp_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic chk_reg(input string tag, input logic [3:0] a, input logic [31:0] exp);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  task automatic drive_pins(input logic [31:0] p);
    @(negedge clk);
    pin_in = p;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; pin_in = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk_reg("R1 dir", 4'd0, 32'h0);
    chk_reg("R1 pol", 4'd1, 32'h0);
    chk_reg("R1 val", 4'd2, 32'h0);
    chk_reg("R1 cause", 4'd5, 32'h0);
    chk_reg("R1 mask", 4'd6, 32'h0);
    chk_reg("R1 ctrl", 4'd8, 32'h11ff0000);
    chk("R1 irq", {28'h0, grp_irq}, 32'h0);
    chk("R1 oe", pin_oe, 32'h0);
  endtask

  task automatic t_value_write();
    do_reset();
    wr(4'd0, 32'h0000ffff);
    wr(4'd2, 32'haaaaaaaa);
    chk_reg("R2 val", 4'd2, 32'h0000aaaa);
    chk("R2 pin_out", pin_out, 32'h0000aaaa);
    chk("R2 pin_oe", pin_oe, 32'h0000ffff);
  endtask

  task automatic t_set_clear();
    do_reset();
    wr(4'd0, 32'h000000ff);
    wr(4'd3, 32'hffffff0f);
    chk_reg("R3 set", 4'd2, 32'h0000000f);
    wr(4'd4, 32'hffff0003);
    chk_reg("R3 clear", 4'd2, 32'h0000000c);
    chk_reg("R3 set alias reads 0", 4'd3, 32'h0);
    chk_reg("R3 clear alias reads 0", 4'd4, 32'h0);
  endtask

  task automatic t_polarity();
    do_reset();
    wr(4'd1, 32'h000000f0);
    repeat (3) @(negedge clk);
    chk_reg("R4 inverted val", 4'd2, 32'h000000f0);
    chk_reg("R4 inverted cause", 4'd5, 32'h000000f0);
    drive_pins(32'h00000010);
    chk_reg("R4 inverted high pin", 4'd2, 32'h000000e0);
  endtask

  task automatic t_rise_latency();
    do_reset();
    wr(4'd6, 32'h00000100);
    @(negedge clk);
    pin_in = 32'h00000100;
    repeat (2) @(negedge clk);
    chk_reg("R12 val not yet", 4'd2, 32'h0);
    chk("R12 irq not yet", {28'h0, grp_irq}, 32'h0);
    @(negedge clk);
    chk_reg("R12 val at third edge", 4'd2, 32'h00000100);
    chk_reg("R5 cause", 4'd5, 32'h00000100);
    chk("R5 irq group1", {28'h0, grp_irq}, 32'h2);
  endtask

  task automatic t_masked();
    do_reset();
    drive_pins(32'h01000000);
    chk_reg("R6 cause", 4'd5, 32'h01000000);
    chk("R6 no irq", {28'h0, grp_irq}, 32'h0);
  endtask

  task automatic t_edge_clear();
    do_reset();
    wr(4'd6, 32'h00000101);
    drive_pins(32'h00000101);
    chk("R8 two groups raised", {28'h0, grp_irq}, 32'h3);
    drive_pins(32'h0);
    chk_reg("R7 fall clears val", 4'd2, 32'h0);
    chk("R8 edge fall keeps irq", {28'h0, grp_irq}, 32'h3);
    wr(4'd5, 32'h00000100);
    chk("R8 group0 cleared only", {28'h0, grp_irq}, 32'h2);
    wr(4'd5, 32'h0);
    chk("R8 group1 cleared", {28'h0, grp_irq}, 32'h0);
  endtask

  task automatic t_level();
    do_reset();
    wr(4'd8, 32'h00000400);
    chk_reg("R10 ctrl level", 4'd8, 32'h11ff0400);
    wr(4'd7, 32'h00000003);
    chk_reg("R11 alias A", 4'd6, 32'h00000003);
    drive_pins(32'h00000003);
    chk("R7 level raised", {28'h0, grp_irq}, 32'h1);
    drive_pins(32'h00000002);
    chk("R7 partial fall holds", {28'h0, grp_irq}, 32'h1);
    wr(4'd5, 32'h0);
    chk("R9 cause write holds", {28'h0, grp_irq}, 32'h1);
    chk_reg("R9 cause stored", 4'd5, 32'h0);
    drive_pins(32'h0);
    chk("R7 group low clears", {28'h0, grp_irq}, 32'h0);
    wr(4'd8, 32'h0);
    chk_reg("R10 ctrl edge", 4'd8, 32'h11ff0000);
  endtask

  task automatic t_mask_alias();
    do_reset();
    wr(4'd6, 32'h12345678);
    chk_reg("R11 read B", 4'd7, 32'h12345678);
    wr(4'd7, 32'hcafe0000);
    chk_reg("R11 read A", 4'd6, 32'hcafe0000);
  endtask

  initial begin
    #(4 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_value_write();
    t_set_clear();
    t_polarity();
    t_rise_latency();
    t_masked();
    t_edge_clear();
    t_level();
    t_mask_alias();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule